// File: doc/BRIEF.md
# Embedded-Clock Serial Symbol Framer

This block packs one 16-bit pixel word per pixel period into a 28-bit serial symbol and shifts it out one bit per serial clock. Each symbol opens with a bit that is always high and closes with a bit that is always low. These two bits act as an embedded clock. Between them sit the payload, a 4-bit CRC and padding. The payload is XORed with a running pseudo-random mask, so the line carries no long runs and stays near DC balance on an AC-coupled link.

The same block holds the matching receiver. It watches the incoming bit stream for the low-to-high step at symbol edges and aligns to it. Once the step has shown up in enough consecutive symbols, it declares lock. From then on it removes the mask, recomputes the CRC and delivers each word with an error flag.

The whole block runs on the serial clock. The pixel rate is given to it as a one-cycle tick every 28 serial clocks. In normal use the serial output is looped to the serial input of the far-end instance.

Top module: `sym_framer`

## Requirements
- R1: On a cycle with `pix_tick` high a symbol is loaded. Its 28 bits appear on `ser_out` from the next cycle on, one per cycle, in this order: bit 0 is 1, bits 1..16 are the masked payload (MSB first), bits 17..20 are the CRC (MSB first), bits 21..26 are 0 and bit 27 is 0.
- R2: The mask is `{s[14:0], s[14]^s[13]}`, taken from a 15-bit state `s`. The state is all ones after reset. Each symbol uses the current state and then steps it once to `{s[13:0], s[14]^s[13]}`. The receiver keeps its own copy, which steps once per evaluated symbol edge.
- R3: The CRC uses the polynomial x^4+x+1 with a zero start value. It is computed MSB first over the unmasked 16-bit payload.
- R4: When `pix_valid` is low at the tick, the payload sent is 0x0000.
- R5: The receiver raises `rx_locked` after LOCK_N consecutive symbol edges that each show a 1 followed by seven 0s at the symbol's tail. The first word it delivers is the LOCK_N-th symbol sent after reset.
- R6: While locked, each clean symbol gives one `rx_valid` pulse. That pulse carries the original word on `rx_data` and has `rx_err` low.
- R7: A corrupted payload or CRC bit gives `rx_err` high for that word, and lock is kept.
- R8: When the edge pattern is missing (a flipped leading bit or padding bit) and fewer than MISS_N misses have occurred in a row, the word is still delivered with `rx_err` high and lock is kept. The MISS_N-th consecutive miss drops `rx_locked` and delivers no word.
- R9: Reset holds `ser_out`, `rx_valid` and `rx_locked` low.
- R10: After lock is lost, the receiver searches again and relocks on a clean stream.
- R11: `rx_valid` is high only while `rx_locked` is high. Two pulses are never closer than 28 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_tick | input | 1 | Pixel-period strobe, one cycle in every 28 |
| pix_valid | input | 1 | Pixel word is valid at the tick |
| pix_data | input | 16 | Pixel word |
| ser_out | output | 1 | Serial symbol stream |
| ser_in | input | 1 | Received serial stream |
| rx_valid | output | 1 | One-cycle pulse per delivered word |
| rx_data | output | 16 | Recovered word |
| rx_err | output | 1 | CRC mismatch or missing edge pattern for this word |
| rx_locked | output | 1 | Receiver is aligned to symbol edges |

## Verification
The assertions check several properties on every cycle:
- the fixed leading one and trailing zeros of each transmitted symbol;
- that words arrive only while locked and never closer than one symbol period apart;
- that the rise of lock coincides with the first delivered word.

Other behaviour only the bench scenarios can show:
- the masked payload and CRC values themselves;
- the exact symbol at which lock is declared;
- the single-miss tolerance and the double-miss loss;
- relocking after a loss.

The bench shows these by sweeping payload patterns and flipping chosen line bits at known symbol positions.

// File: rtl/sym_framer.sv
module sym_framer #(
  parameter int LOCK_N = 4,
  parameter int MISS_N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_tick,
  input  logic        pix_valid,
  input  logic [15:0] pix_data,
  output logic        ser_out,
  input  logic        ser_in,
  output logic        rx_valid,
  output logic [15:0] rx_data,
  output logic        rx_err,
  output logic        rx_locked
);
  localparam int SYM_W   = 28;
  localparam int DAT_W   = 16;
  localparam int CRC_W   = 4;
  localparam int SCR_W   = 15;
  localparam int DAT_LSB = SYM_W - 1 - DAT_W;
  localparam int CRC_LSB = DAT_LSB - CRC_W;
  localparam int PH_W    = $clog2(SYM_W);
  localparam int GC_W    = $clog2(LOCK_N + 1);
  localparam int MC_W    = $clog2(MISS_N + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SYM_W - 1);

  typedef enum logic [1:0] {HUNT, ACQ, LOCK} rx_st_t;

  function automatic logic [CRC_W-1:0] crc_of(input logic [DAT_W-1:0] w);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = DAT_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ w[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic [DAT_W-1:0] mask_of(input logic [SCR_W-1:0] s);
    return {s, s[SCR_W-1] ^ s[SCR_W-2]};
  endfunction

  function automatic logic [SCR_W-1:0] scr_step(input logic [SCR_W-1:0] s);
    return {s[SCR_W-2:0], s[SCR_W-1] ^ s[SCR_W-2]};
  endfunction

  // transmit side
  logic [SYM_W-1:0] tx_sh;
  logic [SCR_W-1:0] tx_scr;
  logic [DAT_W-1:0] tx_word;

  assign tx_word = pix_valid ? pix_data : '0;
  assign ser_out = tx_sh[SYM_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      tx_scr <= '1;
    end else if (pix_tick) begin
      tx_sh  <= {1'b1, tx_word ^ mask_of(tx_scr), crc_of(tx_word), {CRC_LSB{1'b0}}};
      tx_scr <= scr_step(tx_scr);
    end else begin
      tx_sh  <= {tx_sh[SYM_W-2:0], 1'b0};
    end
  end

  // receive side
  rx_st_t           st;
  logic [SYM_W-1:0] win;
  logic [SCR_W-1:0] rx_scr;
  logic [PH_W-1:0]  phase;
  logic [GC_W-1:0]  good_cnt;
  logic [MC_W-1:0]  miss_cnt;
  logic [DAT_W-1:0] rx_word;
  logic             marker, crc_bad, edge_due;

  assign marker    = win[SYM_W-1] & ~|win[CRC_LSB-1:0];
  assign rx_word   = win[SYM_W-2:DAT_LSB] ^ mask_of(rx_scr);
  assign crc_bad   = crc_of(rx_word) != win[DAT_LSB-1:CRC_LSB];
  assign edge_due  = (st != HUNT) && (phase == PH_LAST);
  assign rx_locked = (st == LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= HUNT;
      win      <= '0;
      rx_scr   <= '1;
      phase    <= '0;
      good_cnt <= '0;
      miss_cnt <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_err   <= 1'b0;
    end else begin
      win      <= {win[SYM_W-2:0], ser_in};
      rx_valid <= 1'b0;
      if (st != HUNT) phase <= edge_due ? '0 : phase + 1'b1;
      unique case (st)
        HUNT: if (marker) begin
          st       <= ACQ;
          phase    <= '0;
          good_cnt <= GC_W'(1);
          rx_scr   <= scr_step(rx_scr);
        end
        ACQ: if (edge_due) begin
          rx_scr <= scr_step(rx_scr);
          if (!marker) begin
            st <= HUNT;
          end else if (good_cnt == GC_W'(LOCK_N - 1)) begin
            st       <= LOCK;
            miss_cnt <= '0;
            rx_valid <= 1'b1;
            rx_data  <= rx_word;
            rx_err   <= crc_bad;
          end else begin
            good_cnt <= good_cnt + 1'b1;
          end
        end
        LOCK: if (edge_due) begin
          rx_scr  <= scr_step(rx_scr);
          rx_data <= rx_word;
          if (marker) begin
            miss_cnt <= '0;
            rx_valid <= 1'b1;
            rx_err   <= crc_bad;
          end else if (miss_cnt == MC_W'(MISS_N - 1)) begin
            st <= HUNT;
          end else begin
            miss_cnt <= miss_cnt + 1'b1;
            rx_valid <= 1'b1;
            rx_err   <= 1'b1;
          end
        end
        default: st <= HUNT;
      endcase
    end
  end
endmodule

// File: rtl/sym_framer_chk.sv
module sym_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_tick,
  input logic ser_out,
  input logic rx_valid,
  input logic rx_locked
);
  logic [4:0] since_tick;
  logic       tick_seen;
  logic [4:0] since_word;
  logic       word_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_tick <= '0;
      tick_seen  <= 1'b0;
      since_word <= '0;
      word_seen  <= 1'b0;
    end else begin
      if (pix_tick) begin
        since_tick <= '0;
        tick_seen  <= 1'b1;
      end else if (since_tick != 5'd31) begin
        since_tick <= since_tick + 1'b1;
      end
      if (rx_valid) begin
        since_word <= '0;
        word_seen  <= 1'b1;
      end else if (since_word != 5'd31) begin
        since_word <= since_word + 1'b1;
      end
    end
  end

  assert_lead_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick |=> ser_out);

  assert_tail_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_seen && since_tick >= 5'd21 && since_tick <= 5'd27) |-> !ser_out);

  assert_word_when_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_locked);

  assert_word_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && word_seen) |-> since_word >= 5'd27);

  assert_lock_brings_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_locked) |-> rx_valid);
endmodule

bind sym_framer sym_framer_chk u_chk (.*);

// File: tb/sim_sym_framer.sv
`timescale 1ns/1ps
module sim_sym_framer;
  localparam int LOCK_N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_tick = 1'b0;
  logic        pix_valid = 1'b0;
  logic [15:0] pix_data = '0;
  logic        flip = 1'b0;
  wire         ser_out;
  wire         ser_line;
  wire         rx_valid;
  wire  [15:0] rx_data;
  wire         rx_err;
  wire         rx_locked;

  assign ser_line = ser_out ^ flip;

  sym_framer #(.LOCK_N(LOCK_N), .MISS_N(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .pix_valid(pix_valid),
    .pix_data(pix_data), .ser_out(ser_out), .ser_in(ser_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rx_locked(rx_locked)
  );

  always #2 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  bit mon_en = 1'b1;
  int sym_no = 0;
  int rx_idx = LOCK_N - 1;
  int rx_cnt = 0;
  logic [14:0] b_scr = '1;
  logic [15:0] exp_dat [0:255];
  logic        exp_err [0:255];
  logic        exp_cmp [0:255];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] b_crc(input logic [15:0] w);
    logic [3:0] c = 4'h0;
    for (int i = 15; i >= 0; i--) begin
      logic top = c[3] ^ w[i];
      c = {c[2:0], 1'b0} ^ (top ? 4'h3 : 4'h0);
    end
    return c;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      rx_idx = LOCK_N - 1;
      rx_cnt = 0;
    end else if (rx_valid && mon_en) begin
      check(rx_err == exp_err[rx_idx], $sformatf("R6/R7/R8 err flag word %0d", rx_idx),
            32'(rx_err), 32'(exp_err[rx_idx]));
      if (exp_cmp[rx_idx])
        check(rx_data == exp_dat[rx_idx], $sformatf("R6 data word %0d", rx_idx),
              32'(rx_data), 32'(exp_dat[rx_idx]));
      rx_idx++;
      rx_cnt++;
    end
  end

  task automatic send(input logic [15:0] d, input logic v, input int flip_at,
                      input logic e_err, input logic e_cmp);
    logic [15:0] w;
    logic [27:0] exp_sym;
    logic [27:0] got;
    w = v ? d : 16'h0;
    exp_sym = {1'b1, w ^ {b_scr, b_scr[14] ^ b_scr[13]}, b_crc(w), 7'b0};
    b_scr = {b_scr[13:0], b_scr[14] ^ b_scr[13]};
    exp_dat[sym_no] = w;
    exp_err[sym_no] = e_err;
    exp_cmp[sym_no] = e_cmp;
    sym_no++;
    pix_data = d;
    pix_valid = v;
    pix_tick = 1'b1;
    @(posedge clk);
    flip = 1'b0;
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      if (i == 0) pix_tick = 1'b0;
      flip = (i == flip_at);
      got[27-i] = ser_out;
    end
    check(got == exp_sym, $sformatf("R1/R2/R3/R4 symbol %0d", sym_no - 1), 32'(got), 32'(exp_sym));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pix_tick = 1'b0;
    flip = 1'b0;
    b_scr = '1;
    sym_no = 0;
    mon_en = 1'b1;
    repeat (2) @(negedge clk);
    check(ser_out == 1'b0 && rx_valid == 1'b0 && rx_locked == 1'b0, "R9 reset state",
          {29'b0, ser_out, rx_valid, rx_locked}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int base;
    do_reset();
    // R5: acquisition while sweeping patterns
    for (int k = 0; k < 34; k++) begin
      logic [15:0] d;
      if (k == 0) d = 16'h0000;
      else if (k == 1) d = 16'hFFFF;
      else if (k < 18) d = 16'h1 << (k - 2);
      else d = ~(16'h1 << (k - 18));
      send(d, 1'b1, -1, 1'b0, 1'b1);
      if (sym_no == LOCK_N) check(rx_locked == 1'b0, "R5 not yet locked", 32'(rx_locked), 32'h0);
      if (sym_no == LOCK_N + 1) check(rx_locked == 1'b1, "R5 locked", 32'(rx_locked), 32'h1);
    end
    for (int k = 0; k < 12; k++) send(16'(k * 40503 + 7), 1'b1, -1, 1'b0, 1'b1);
    // R4: invalid pixels carry a zero payload
    for (int k = 0; k < 3; k++) send(16'hA5C3 + 16'(k), 1'b0, -1, 1'b0, 1'b1);
    // R7: payload bit and CRC bit corruption
    send(16'h1234, 1'b1, 5, 1'b1, 1'b0);
    send(16'h5678, 1'b1, -1, 1'b0, 1'b1);
    check(rx_locked == 1'b1, "R7 lock kept after payload error", 32'(rx_locked), 32'h1);
    send(16'h9ABC, 1'b1, 18, 1'b1, 1'b0);
    send(16'hDEF0, 1'b1, -1, 1'b0, 1'b1);
    check(rx_locked == 1'b1, "R7 lock kept after CRC error", 32'(rx_locked), 32'h1);
    // R8: single misses on padding and leading bit
    send(16'h0F0F, 1'b1, 23, 1'b1, 1'b0);
    send(16'hF0F0, 1'b1, -1, 1'b0, 1'b1);
    check(rx_locked == 1'b1, "R8 lock kept after padding miss", 32'(rx_locked), 32'h1);
    send(16'h3C3C, 1'b1, 0, 1'b1, 1'b0);
    send(16'hC3C3, 1'b1, -1, 1'b0, 1'b1);
    check(rx_locked == 1'b1, "R8 lock kept after leading-bit miss", 32'(rx_locked), 32'h1);
    send(16'h7777, 1'b1, -1, 1'b0, 1'b1);
    check(rx_cnt == sym_no - LOCK_N, "R6 word count", 32'(rx_cnt), 32'(sym_no - LOCK_N));
    // R8: two consecutive misses drop lock
    send(16'h1111, 1'b1, 0, 1'b1, 1'b0);
    send(16'h2222, 1'b1, 0, 1'b1, 1'b0);
    mon_en = 1'b0;
    base = rx_cnt;
    send(16'h3333, 1'b1, -1, 1'b0, 1'b0);
    check(rx_locked == 1'b0, "R8 lock lost after two misses", 32'(rx_locked), 32'h0);
    check(rx_cnt == base, "R8 no word on second miss", 32'(rx_cnt), 32'(base));
    // R10: relock on clean stream
    for (int k = 0; k < 20 && !rx_locked; k++) send(16'(k * 9001), 1'b1, -1, 1'b0, 1'b0);
    check(rx_locked == 1'b1, "R10 relock", 32'(rx_locked), 32'h1);
    // fresh start after reset
    do_reset();
    for (int k = 0; k < 14; k++) send(16'(k * 12345 + 99), k != 6, -1, 1'b0, 1'b1);
    check(rx_locked == 1'b1, "R5 locked after reset", 32'(rx_locked), 32'h1);
    check(rx_cnt == sym_no - LOCK_N, "R6 word count after reset", 32'(rx_cnt), 32'(sym_no - LOCK_N));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule